// File: doc/BRIEF.md
# Byte-Write Completion Poller

This helper sits on the master side of a serial programming link. It runs after a flash or EEPROM byte-write command has been sent to a target device. It then decides when the next command may follow. It works in one of two ways.

- **Polling.** The device supports polling and the written byte differs from the value the device returns while it is still programming (the busy marker). In this case the block sends repeated four-byte read frames to the written address. It compares the last byte of each reply with the written data. A match means the write has finished.
- **Fixed delay.** The device does not support polling, or the written byte equals the busy marker, so a reply cannot tell busy from done. In this case the block waits a fixed number of milliseconds, counted in system clock ticks through a prescaler.

Shifting the bits on the serial wires is left to a separate frame engine. This block talks to that engine through a request/response handshake carrying whole 32-bit frames. Polling gives up after a set number of read frames and reports a failure.

Top module: `wrDonePoller`

## Requirements
- R1: After reset, `ready` is high, `wrDone` and `wrFail` are low, and `frmReqValid` is low.
- R2: A start with `pollEn`=1 and `wrData` different from `busyMark` selects polling. Each request frame is {`rdOpcode` in bits 31:24, the address zero-extended to 16 bits in bits 23:8, 0x00 in bits 7:0}.
- R3: A response whose bits 7:0 equal the written data ends the operation. `wrDone` goes high for the cycle after that response, with `wrFail` low.
- R4: Only one request is outstanding at a time. A request held without `frmReqReady` keeps its frame stable. A mismatching response, while the limit is not yet reached, leads to a new request.
- R5: Polling reports `wrDone` together with `wrFail` once `pollLimit` frames have been answered without a match. A limit of 0 behaves as 1. A match on the last allowed frame counts as success.
- R6: When `wrData` equals `busyMark`, the fixed delay is used and no frame is requested, even with `pollEn`=1.
- R7: With `pollEn`=0 the fixed delay is always used and no frame is requested.
- R8: In delay mode, `wrDone` rises `delayMs`×`TICKS_PER_MS` clock edges after the start edge. A `delayMs` of 0 gives `wrDone` right after the start edge.
- R9: `ready` is low during an operation. A `start` or `frmRspValid` arriving while busy, outside the wait for a reply, has no effect on the result or its timing.
- R10: `wrDone` is a single-cycle pulse. `wrFail` is never high without `wrDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin completion handling for a just-sent write (taken only while ready) |
| wrAddr | input | ADDR_W | Address of the written location |
| wrData | input | 8 | Byte that was written |
| rdOpcode | input | 8 | Read command byte for the written memory |
| pollEn | input | 1 | Device supports polling |
| busyMark | input | 8 | Value read back while programming is in progress |
| delayMs | input | MS_W | Fixed delay in milliseconds |
| pollLimit | input | POLL_W | Maximum number of poll frames |
| ready | output | 1 | Idle and able to accept a start |
| wrDone | output | 1 | Operation complete (one cycle) |
| wrFail | output | 1 | Polling gave up; valid with wrDone |
| frmReqValid | output | 1 | Frame request to the engine |
| frmReqReady | input | 1 | Engine accepts the request |
| frmReqData | output | 32 | Four-byte frame, first byte in bits 31:24 |
| frmRspValid | input | 1 | Engine reply strobe |
| frmRspData | input | 32 | Reply frame; last byte in bits 7:0 |

## Verification
The assertions take four things for granted about the inputs:
- `wrData`, `busyMark` and `pollEn` are valid in the cycle where `start` meets `ready`.
- The frame engine answers each accepted frame exactly once.
- The engine never answers in the same cycle it accepts a frame.
- `frmReqReady` is only meaningful while a request is pending.

The bench's engine model keeps to these rules:
- It raises ready only against a visible request, sometimes after a stall of a few cycles.
- It returns one reply two cycles after each accept.

The only stray replies the bench injects fall in the fixed-delay wait, which the requirements say must ignore them.

// File: rtl/wrDonePollerPkg.sv
package wrDonePollerPkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 4 * BYTE_W;
  localparam int FADDR_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WAIT  = 2'd3
  } pollState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic delayRun;
    logic frameSent;
  } ctlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic dataIsMark;
    logic delayIsZero;
    logic delayLast;
    logic rspMatch;
    logic limitHit;
  } dpStatus_t;
endpackage

// File: rtl/wrDonePollerDp.sv
module wrDonePollerDp
  import wrDonePollerPkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int MS_W         = 8,
  parameter int POLL_W       = 8,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [BYTE_W-1:0]   rdOpcode,
  input  logic [BYTE_W-1:0]   busyMark,
  input  logic [MS_W-1:0]     delayMs,
  input  logic [POLL_W-1:0]   pollLimit,
  input  logic [BYTE_W-1:0]   rspByte,
  output dpStatus_t           status,
  output logic [FRAME_W-1:0]  frame
);
  localparam int PRESC_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LOAD = PRESC_W'(TICKS_PER_MS - 1);

  logic [ADDR_W-1:0]  addrQ;
  logic [BYTE_W-1:0]  dataQ;
  logic [BYTE_W-1:0]  opQ;
  logic [POLL_W-1:0]  limitQ;
  logic [POLL_W-1:0]  pollCnt;
  logic [MS_W-1:0]    msLeft;
  logic [PRESC_W-1:0] presc;
  logic [FADDR_W-1:0] addrWide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      opQ     <= '0;
      limitQ  <= '0;
      pollCnt <= '0;
      msLeft  <= '0;
      presc   <= '0;
    end else if (strobe.capture) begin
      addrQ   <= wrAddr;
      dataQ   <= wrData;
      opQ     <= rdOpcode;
      limitQ  <= pollLimit;
      pollCnt <= '0;
      msLeft  <= delayMs;
      presc   <= PRESC_LOAD;
    end else begin
      if (strobe.delayRun) begin
        if (presc == '0) begin
          presc  <= PRESC_LOAD;
          msLeft <= msLeft - 1'b1;
        end else begin
          presc <= presc - 1'b1;
        end
      end
      if (strobe.frameSent) pollCnt <= pollCnt + 1'b1;
    end
  end

  generate
    if (ADDR_W < FADDR_W) begin : g_padAddr
      assign addrWide = {{(FADDR_W - ADDR_W){1'b0}}, addrQ};
    end else begin : g_fullAddr
      assign addrWide = addrQ[FADDR_W-1:0];
    end
  endgenerate

  assign frame = {opQ, addrWide, {BYTE_W{1'b0}}};

  always_comb begin
    status.dataIsMark  = (wrData == busyMark);
    status.delayIsZero = (delayMs == '0);
    status.delayLast   = (presc == '0) && (msLeft == MS_W'(1));
    status.rspMatch    = (rspByte == dataQ);
    status.limitHit    = (pollCnt >= limitQ);
  end
endmodule

// File: rtl/wrDonePollerCtl.sv
module wrDonePollerCtl
  import wrDonePollerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       pollEn,
  input  logic       frmReqReady,
  input  logic       frmRspValid,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       ready,
  output logic       frmReqValid,
  output logic       wrDone,
  output logic       wrFail
);
  pollState_e st, stNxt;
  logic doneNxt, failNxt, usePoll;

  assign usePoll = pollEn && !status.dataIsMark;

  always_comb begin
    stNxt   = st;
    strobe  = '0;
    doneNxt = 1'b0;
    failNxt = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          if (usePoll)                  stNxt = ST_ISSUE;
          else if (!status.delayIsZero) stNxt = ST_DELAY;
          else                          doneNxt = 1'b1;
        end
      end
      ST_DELAY: begin
        strobe.delayRun = 1'b1;
        if (status.delayLast) begin
          stNxt   = ST_IDLE;
          doneNxt = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (frmReqReady) begin
          strobe.frameSent = 1'b1;
          stNxt = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (frmRspValid) begin
          if (status.rspMatch || status.limitHit) begin
            stNxt   = ST_IDLE;
            doneNxt = 1'b1;
            failNxt = !status.rspMatch;
          end else begin
            stNxt = ST_ISSUE;
          end
        end
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st     <= ST_IDLE;
      wrDone <= 1'b0;
      wrFail <= 1'b0;
    end else begin
      st     <= stNxt;
      wrDone <= doneNxt;
      wrFail <= failNxt;
    end
  end

  assign ready       = (st == ST_IDLE);
  assign frmReqValid = (st == ST_ISSUE);
endmodule

// File: rtl/wrDonePoller.sv
module wrDonePoller
  import wrDonePollerPkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int MS_W         = 8,
  parameter int POLL_W       = 8,
  parameter int TICKS_PER_MS = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [7:0]         wrData,
  input  logic [7:0]         rdOpcode,
  input  logic               pollEn,
  input  logic [7:0]         busyMark,
  input  logic [MS_W-1:0]    delayMs,
  input  logic [POLL_W-1:0]  pollLimit,
  output logic               ready,
  output logic               wrDone,
  output logic               wrFail,
  output logic               frmReqValid,
  input  logic               frmReqReady,
  output logic [31:0]        frmReqData,
  input  logic               frmRspValid,
  input  logic [31:0]        frmRspData
);
  ctlStrobe_t strobe;
  dpStatus_t  status;

  wrDonePollerCtl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .pollEn      (pollEn),
    .frmReqReady (frmReqReady),
    .frmRspValid (frmRspValid),
    .status      (status),
    .strobe      (strobe),
    .ready       (ready),
    .frmReqValid (frmReqValid),
    .wrDone      (wrDone),
    .wrFail      (wrFail)
  );

  wrDonePollerDp #(
    .ADDR_W       (ADDR_W),
    .MS_W         (MS_W),
    .POLL_W       (POLL_W),
    .TICKS_PER_MS (TICKS_PER_MS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdOpcode  (rdOpcode),
    .busyMark  (busyMark),
    .delayMs   (delayMs),
    .pollLimit (pollLimit),
    .rspByte   (frmRspData[BYTE_W-1:0]),
    .status    (status),
    .frame     (frmReqData)
  );
endmodule

// File: rtl/wrDonePollerChk.sv
module wrDonePollerChk #(
  parameter int ADDR_W = 16,
  parameter int MS_W   = 8,
  parameter int POLL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic              pollEn,
  input logic [7:0]        busyMark,
  input logic              ready,
  input logic              wrDone,
  input logic              wrFail,
  input logic              frmReqValid,
  input logic              frmReqReady,
  input logic [31:0]       frmReqData
);
  // R10
  fail_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrFail |-> wrDone);

  // R3
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |-> ready);

  // R9
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmReqValid |-> !ready);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frmReqValid && !frmReqReady) |=> (frmReqValid && $stable(frmReqData)));

  // R2
  poll_first_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && ready && pollEn && (wrData != busyMark)) |=>
      (frmReqValid && (frmReqData[7:0] == 8'h00) &&
       (frmReqData[15:8] == $past(wrAddr[7:0]))));

  // R6
  mark_uses_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && ready && (wrData == busyMark)) |=> !frmReqValid);

  // R7
  nopoll_uses_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && ready && !pollEn) |=> !frmReqValid);
endmodule

bind wrDonePoller wrDonePollerChk #(
  .ADDR_W (ADDR_W),
  .MS_W   (MS_W),
  .POLL_W (POLL_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .wrAddr      (wrAddr),
  .wrData      (wrData),
  .pollEn      (pollEn),
  .busyMark    (busyMark),
  .ready       (ready),
  .wrDone      (wrDone),
  .wrFail      (wrFail),
  .frmReqValid (frmReqValid),
  .frmReqReady (frmReqReady),
  .frmReqData  (frmReqData)
);

// File: tb/test_wrDonePoller.sv
`timescale 1ns/1ps
module test_wrDonePoller;
  localparam int TICKS = 4;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdOpcode = '0;
  logic        pollEn = 1'b0;
  logic [7:0]  busyMark = 8'hFF;
  logic [7:0]  delayMs = '0;
  logic [7:0]  pollLimit = '0;
  logic        ready, wrDone, wrFail, frmReqValid;
  logic        frmReqReady = 1'b0;
  logic [31:0] frmReqData;
  logic        frmRspValid = 1'b0;
  logic [31:0] frmRspData = '0;

  always #5 clk = ~clk;

  wrDonePoller #(.TICKS_PER_MS(TICKS)) i_wrDonePoller (
    .clk(clk), .rstN(rstN), .start(start), .wrAddr(wrAddr), .wrData(wrData),
    .rdOpcode(rdOpcode), .pollEn(pollEn), .busyMark(busyMark), .delayMs(delayMs),
    .pollLimit(pollLimit), .ready(ready), .wrDone(wrDone), .wrFail(wrFail),
    .frmReqValid(frmReqValid), .frmReqReady(frmReqReady), .frmReqData(frmReqData),
    .frmRspValid(frmRspValid), .frmRspData(frmRspData)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // frame engine model
  int          frames = 0;
  int          rspIdx = 0;
  int          pend = 0;
  int          stallCnt = 0;
  int          stallN = 0;
  int          busyR = 0;
  logic [31:0] lastFrame = '0;
  logic        injectRsp = 1'b0;

  always @(negedge clk) begin
    if (!rstN) begin
      frmReqReady = 1'b0; frmRspValid = 1'b0; pend = 0; stallCnt = 0;
    end else begin
      frmRspValid = 1'b0;
      if (injectRsp) begin
        frmRspValid = 1'b1;
        frmRspData  = {24'h0, wrData};
        injectRsp   = 1'b0;
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          frmRspValid = 1'b1;
          frmRspData  = {lastFrame[31:8], (rspIdx < busyR) ? busyMark : wrData};
          rspIdx++;
        end
      end
      if (frmReqValid) begin
        if (stallCnt < stallN) begin
          frmReqReady = 1'b0; stallCnt++;
        end else begin
          frmReqReady = 1'b1; frames++; lastFrame = frmReqData;
          pend = LAT; stallCnt = 0;
        end
      end else begin
        frmReqReady = 1'b0;
      end
    end
  end

  typedef struct packed {
    logic        pollEn;
    logic [7:0]  data;
    logic [7:0]  mark;
    logic [7:0]  dly;
    logic [7:0]  limit;
    logic [7:0]  busyR;
    logic [1:0]  stall;
    logic        expDelay;
    logic        expErr;
    logic [7:0]  expFrames;
    logic [15:0] addr;
    logic [7:0]  op;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 8'h12, 8'hFF, 8'd3, 8'd8, 8'd2,  2'd0, 1'b0, 1'b0, 8'd3, 16'h010C, 8'h20},
    '{1'b1, 8'hFF, 8'hFF, 8'd2, 8'd8, 8'd0,  2'd0, 1'b1, 1'b0, 8'd0, 16'h0011, 8'hA0},
    '{1'b0, 8'h34, 8'hFF, 8'd3, 8'd8, 8'd0,  2'd0, 1'b1, 1'b0, 8'd0, 16'h0104, 8'h28},
    '{1'b1, 8'h56, 8'hFF, 8'd3, 8'd3, 8'd10, 2'd1, 1'b0, 1'b1, 8'd3, 16'h0200, 8'h20},
    '{1'b1, 8'h00, 8'hFF, 8'd1, 8'd4, 8'd0,  2'd2, 1'b0, 1'b0, 8'd1, 16'h003F, 8'hA0},
    '{1'b1, 8'hFF, 8'h80, 8'd1, 8'd4, 8'd1,  2'd0, 1'b0, 1'b0, 8'd2, 16'h0FFF, 8'h28},
    '{1'b0, 8'h77, 8'hFF, 8'd0, 8'd4, 8'd0,  2'd0, 1'b1, 1'b0, 8'd0, 16'h0001, 8'hA0},
    '{1'b1, 8'h9A, 8'hFF, 8'd1, 8'd3, 8'd2,  2'd0, 1'b0, 1'b0, 8'd3, 16'h1234, 8'h20},
    '{1'b1, 8'hBC, 8'hFF, 8'd1, 8'd0, 8'd5,  2'd0, 1'b0, 1'b1, 8'd1, 16'h00AA, 8'h20}
  };

  int cycles;
  logic gotFail;

  task automatic waitDone();
    cycles = 0;
    while (!wrDone && cycles < 2000) begin
      @(posedge clk); @(negedge clk); cycles++;
    end
    if (!wrDone) begin
      errors++; checks++;
      $display("FAIL R3/R8 watchdog: actual no done expected done");
    end
    gotFail = wrFail;
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    frames = 0; rspIdx = 0; busyR = int'(v.busyR); stallN = int'(v.stall);
    pollEn = v.pollEn; wrData = v.data; busyMark = v.mark; delayMs = v.dly;
    pollLimit = v.limit; wrAddr = v.addr; rdOpcode = v.op; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready, 1); chk("R1 wrDone", wrDone, 0);
    chk("R1 wrFail", wrFail, 0); chk("R1 frmReqValid", frmReqValid, 0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      launch(VEC[i]);
      waitDone();
      chk("R3/R5 wrFail at done", gotFail, VEC[i].expErr);
      chk("R2/R4/R5/R6/R7 frame count", frames, VEC[i].expFrames);
      if (VEC[i].expDelay)
        chk("R8 delay cycles", cycles, int'(VEC[i].dly) * TICKS);
      if (VEC[i].expFrames != 0)
        chk("R2 frame layout", lastFrame, {VEC[i].op, VEC[i].addr, 8'h00});
      @(posedge clk); @(negedge clk);
      chk("R10 done pulse", wrDone, 0);
      chk("R10 fail low", wrFail, 0);
      chk("R9 ready after", ready, 1);
    end

    // R9: start and reply while in delay wait are ignored
    launch('{1'b0, 8'h21, 8'hFF, 8'd3, 8'd4, 8'd0, 2'd0, 1'b1, 1'b0, 8'd0, 16'h0050, 8'hA0});
    repeat (4) begin @(posedge clk); @(negedge clk); end
    chk("R9 ready busy", ready, 0);
    start = 1'b1; pollEn = 1'b1; wrData = 8'h44; injectRsp = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    waitDone();
    chk("R9 timing unchanged", cycles + 5, 12);
    chk("R9 no frames", frames, 0);
    chk("R9 no fail", gotFail, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule